// File: doc/BRIEF.md
# Transparent Address Translation Matcher

This block decides, for every bus access, whether the logical address may bypass page-table translation and go out unchanged as the physical address. Two programmable window registers each describe a region of at least 16 MB of logical space. A window is described by an 8-bit address field with a per-bit ignore mask, a 3-bit function-code field with its own ignore mask, and an optional read/write qualifier. The two windows are checked in parallel and may overlap.

An access is presented with a one-cycle strobe. One cycle later the block reports whether a window hit, whether the hit carries a cache-inhibit attribute, and the physical address. On a miss, both flags are low and the access goes on to normal translation. A plain synchronous write/read port lets software load and inspect both window registers.

Top module: `tt_match_unit`

## Requirements
- R1: After reset both window registers read 0, so both windows are disabled, and `res_valid_o`, `hit_o` and `cinh_o` are 0.
- R2: Register layout: [31:24] address base, [23:16] address ignore mask, [15] enable, [10] cache inhibit, [9] direction (1 = read, 0 = write), [8] direction ignore, [6:4] function-code base, [2:0] function-code ignore mask. All other bits ignore writes and read back 0, so writing 0xFFFFFFFF reads back 0xFFFF8777.
- R3: An access strobed at one clock edge produces `res_valid_o`=1 with its result after that edge, for exactly one cycle per strobe. A register write at an edge is seen by accesses sampled at later edges, and is not seen by an access sampled at the same edge.
- R4: Address bits [31:24] must equal the base in every bit whose mask bit is 0. Bits with mask 1 are not compared.
- R5: A window with its enable bit at 0 never hits.
- R6: When direction ignore is 0, `acc_rd_i` must equal the direction bit. When it is 1, the direction of the access does not matter.
- R7: The function code must equal the function-code base in every bit whose mask bit is 0.
- R8: With a result valid, `paddr_o` equals the logical address of that access. On a hit, `cinh_o` is the cache-inhibit bit of the window that hit, and `cinh_o` is never 1 without `hit_o`.
- R9: If both windows hit, `hit_o` is 1 and `cinh_o` is the OR of both windows' cache-inhibit bits.
- R10: On a miss, or in a cycle with no valid result, `hit_o` and `cinh_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | SEL_W | Register select (0 or 1) |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Selected register contents (combinational) |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W | Logical address |
| acc_fc_i | input | 3 | Function code of the access |
| acc_rd_i | input | 1 | 1 = read, 0 = write |
| res_valid_o | output | 1 | Result valid, one cycle after the strobe |
| hit_o | output | 1 | Transparent window hit |
| cinh_o | output | 1 | Cache inhibit for the hit |
| paddr_o | output | ADDR_W | Physical address |

## Verification
A register whose stored bits are wrong, or that keeps reserved bits, shows up on `cfg_rdata_o` in the same cycle it is selected. A field that is compared wrongly, such as an inverted mask, a swapped direction sense or a dropped enable, flips `hit_o` or `cinh_o` in the cycle right after the strobe of the first access that crosses that field's boundary. For this reason the vectors change one field at a time, and two vectors make both windows hit at once. A result stage with wrong timing shows up as a stale or missing `res_valid_o` one cycle after the strobe, and as a write that reaches an access sampled at the same edge.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_REG_W   = 32;
  localparam int LA_FIELD_W = 8;
  localparam int FC_W       = 3;
  localparam logic [TT_REG_W-1:0] TT_WMASK = 32'hFFFF_8777;

  typedef struct packed {
    logic [LA_FIELD_W-1:0] la_base;
    logic [LA_FIELD_W-1:0] la_mask;
    logic                  en;
    logic                  ci;
    logic                  dir_rd;
    logic                  dir_ign;
    logic [FC_W-1:0]       fc_base;
    logic [FC_W-1:0]       fc_mask;
  } tt_cfg_t;

  function automatic tt_cfg_t unpack_cfg(logic [TT_REG_W-1:0] r);
    tt_cfg_t c;
    c.la_base = r[31:24];
    c.la_mask = r[23:16];
    c.en      = r[15];
    c.ci      = r[10];
    c.dir_rd  = r[9];
    c.dir_ign = r[8];
    c.fc_base = r[6:4];
    c.fc_mask = r[2:0];
    return c;
  endfunction
endpackage

// File: rtl/tt_reg_file.sv
module tt_reg_file
  import tt_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int SEL_W   = 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [SEL_W-1:0]                  sel_i,
  input  logic [TT_REG_W-1:0]               wdata_i,
  output logic [TT_REG_W-1:0]               rdata_o,
  output logic [NUM_WIN-1:0][TT_REG_W-1:0]  regs_o
);
  logic [NUM_WIN-1:0][TT_REG_W-1:0] regs_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[w] <= '0;
      end else if (we_i && (int'(sel_i) == w)) begin
        regs_q[w] <= wdata_i & TT_WMASK;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (int'(sel_i) == w) rdata_o = regs_q[w];
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/tt_window_match.sv
module tt_window_match
  import tt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  tt_cfg_t           cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic              rd_i,
  output logic              hit_o,
  output logic              ci_o
);
  localparam int LA_LSB = ADDR_W - LA_FIELD_W;

  logic [LA_FIELD_W-1:0] la_top;
  logic la_ok, fc_ok, dir_ok;

  assign la_top = addr_i[ADDR_W-1:LA_LSB];
  // Mask bit 1 = don't-care
  assign la_ok  = ((la_top ^ cfg_i.la_base) & ~cfg_i.la_mask) == '0;
  assign fc_ok  = ((fc_i ^ cfg_i.fc_base) & ~cfg_i.fc_mask) == '0;
  assign dir_ok = cfg_i.dir_ign | (rd_i == cfg_i.dir_rd);

  assign hit_o = cfg_i.en & la_ok & fc_ok & dir_ok;
  assign ci_o  = hit_o & cfg_i.ci;
endmodule

// File: rtl/tt_result_stage.sv
module tt_result_stage #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_WIN-1:0] win_hit_i,
  input  logic [NUM_WIN-1:0] win_ci_i,
  output logic               res_valid_o,
  output logic               hit_o,
  output logic               cinh_o,
  output logic [ADDR_W-1:0]  paddr_o
);
  logic              vld_q, hit_q, ci_q;
  logic [ADDR_W-1:0] pa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
      ci_q  <= 1'b0;
      pa_q  <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        hit_q <= |win_hit_i;
        ci_q  <= |(win_hit_i & win_ci_i);
        pa_q  <= addr_i;
      end else begin
        hit_q <= 1'b0;
        ci_q  <= 1'b0;
      end
    end
  end

  assign res_valid_o = vld_q;
  assign hit_o       = hit_q;
  assign cinh_o      = ci_q;
  assign paddr_o     = pa_q;
endmodule

// File: rtl/tt_match_unit.sv
module tt_match_unit
  import tt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [SEL_W-1:0]    cfg_sel_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  input  logic                acc_valid_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [2:0]          acc_fc_i,
  input  logic                acc_rd_i,
  output logic                res_valid_o,
  output logic                hit_o,
  output logic                cinh_o,
  output logic [ADDR_W-1:0]   paddr_o
);
  logic [NUM_WIN-1:0][TT_REG_W-1:0] regs;
  logic [NUM_WIN*TT_REG_W-1:0]      regs_flat;
  logic [NUM_WIN-1:0]               win_hit, win_ci;

  tt_reg_file #(
    .NUM_WIN(NUM_WIN),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .regs_o (regs)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    tt_window_match #(.ADDR_W(ADDR_W)) u_match (
      .cfg_i (unpack_cfg(regs[w])),
      .addr_i(acc_addr_i),
      .fc_i  (acc_fc_i),
      .rd_i  (acc_rd_i),
      .hit_o (win_hit[w]),
      .ci_o  (win_ci[w])
    );
    assign regs_flat[w*TT_REG_W +: TT_REG_W] = regs[w];
  end

  tt_result_stage #(
    .ADDR_W (ADDR_W),
    .NUM_WIN(NUM_WIN)
  ) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (acc_valid_i),
    .addr_i     (acc_addr_i),
    .win_hit_i  (win_hit),
    .win_ci_i   (win_ci),
    .res_valid_o(res_valid_o),
    .hit_o      (hit_o),
    .cinh_o     (cinh_o),
    .paddr_o    (paddr_o)
  );
endmodule

// File: rtl/tt_match_unit_chk.sv
module tt_match_unit_chk
  import tt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int SEL_W   = 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cfg_we_i,
  input logic [SEL_W-1:0]            cfg_sel_i,
  input logic [31:0]                 cfg_wdata_i,
  input logic                        acc_valid_i,
  input logic [ADDR_W-1:0]           acc_addr_i,
  input logic                        res_valid_o,
  input logic                        hit_o,
  input logic                        cinh_o,
  input logic [ADDR_W-1:0]           paddr_o,
  input logic [NUM_WIN*TT_REG_W-1:0] regs_flat_i
);
  logic any_en;
  always_comb begin
    any_en = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) any_en |= regs_flat_i[w*TT_REG_W + 15];
  end

  // R3
  res_follows_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> res_valid_o);
  // R3
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !res_valid_o);
  // R8
  paddr_identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> paddr_o == $past(acc_addr_i));
  // R8
  cinh_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cinh_o |-> hit_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!hit_o && !cinh_o));
  // R5
  disabled_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !any_en) |=> !hit_o);
  // R2
  write_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && int'(cfg_sel_i) < NUM_WIN) |=>
      regs_flat_i[int'($past(cfg_sel_i))*TT_REG_W +: TT_REG_W] == ($past(cfg_wdata_i) & TT_WMASK));
endmodule

bind tt_match_unit tt_match_unit_chk #(
  .ADDR_W (ADDR_W),
  .NUM_WIN(NUM_WIN),
  .SEL_W  (SEL_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .cfg_wdata_i(cfg_wdata_i),
  .acc_valid_i(acc_valid_i),
  .acc_addr_i (acc_addr_i),
  .res_valid_o(res_valid_o),
  .hit_o      (hit_o),
  .cinh_o     (cinh_o),
  .paddr_o    (paddr_o),
  .regs_flat_i(regs_flat)
);

// File: tb/tt_match_unit_tb_top.sv
module tt_match_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [31:0] r0;
    logic [31:0] r1;
    logic [31:0] addr;
    logic [2:0]  fc;
    logic        rd;
    logic        hit;
    logic        ci;
  } vec_t;

  // A=40008107 B=400F8650 C=80008507 D=10008016 Aoff=40000107
  localparam vec_t VECS [NVEC] = '{
    '{32'h40008107, 32'h0,        32'h40123456, 3'd1, 1'b1, 1'b1, 1'b0}, // R4 hit
    '{32'h40008107, 32'h0,        32'h41000000, 3'd1, 1'b1, 1'b0, 1'b0}, // R4 miss
    '{32'h40000107, 32'h0,        32'h40000000, 3'd1, 1'b1, 1'b0, 1'b0}, // R5
    '{32'h400F8650, 32'h0,        32'h4F000000, 3'd5, 1'b1, 1'b1, 1'b1}, // R4 masked
    '{32'h400F8650, 32'h0,        32'h4F000000, 3'd5, 1'b0, 1'b0, 1'b0}, // R6
    '{32'h400F8650, 32'h0,        32'h40000000, 3'd4, 1'b1, 1'b0, 1'b0}, // R7
    '{32'h400F8650, 32'h0,        32'h50000000, 3'd5, 1'b1, 1'b0, 1'b0}, // R4
    '{32'h10008016, 32'h0,        32'h10ABCDEF, 3'd7, 1'b0, 1'b1, 1'b0}, // R7 masked
    '{32'h10008016, 32'h0,        32'h10ABCDEF, 3'd6, 1'b0, 1'b0, 1'b0}, // R7
    '{32'h10008016, 32'h0,        32'h10000000, 3'd3, 1'b1, 1'b0, 1'b0}, // R6
    '{32'h40008107, 32'h80008507, 32'h80000010, 3'd2, 1'b0, 1'b1, 1'b1}, // R8
    '{32'h40008107, 32'h400F8650, 32'h40000000, 3'd5, 1'b1, 1'b1, 1'b1}, // R9
    '{32'h0,        32'h400F8650, 32'h4A000000, 3'd5, 1'b1, 1'b1, 1'b1}, // R8
    '{32'h0,        32'h0,        32'h00000000, 3'd0, 1'b0, 1'b0, 1'b0}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [0:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [2:0]  acc_fc_i = '0;
  logic        acc_rd_i = 1'b0;
  logic        res_valid_o, hit_o, cinh_o;
  logic [31:0] paddr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_match_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i), .acc_fc_i(acc_fc_i),
    .acc_rd_i(acc_rd_i),
    .res_valid_o(res_valid_o), .hit_o(hit_o), .cinh_o(cinh_o), .paddr_o(paddr_o)
  );

  function automatic string vreq(int i);
    case (i)
      2: return "R5";
      4, 9: return "R6";
      5, 7, 8: return "R7";
      10, 12: return "R8";
      11: return "R9";
      13: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 1'(sel); cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(int sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel_i = 1'(sel);
    #1 d = cfg_rdata_o;
  endtask

  // Result sampled at the negedge after the strobe edge
  task automatic access(logic [31:0] a, logic [2:0] fc, logic r);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_fc_i = fc; acc_rd_i = r;
    @(negedge clk);
    acc_valid_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(0, d); chk("R1", "reg0 reset", d, 32'h0);
    rd(1, d); chk("R1", "reg1 reset", d, 32'h0);
    chk("R1", "res_valid reset", 32'(res_valid_o), 32'h0);
    chk("R1", "hit reset", 32'(hit_o), 32'h0);
    access(32'h0, 3'd0, 1'b1);
    chk("R1", "zero regs miss", 32'(hit_o), 32'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(0, VECS[i].r0);
      wr(1, VECS[i].r1);
      access(VECS[i].addr, VECS[i].fc, VECS[i].rd);
      chk(vreq(i), $sformatf("vec%0d res_valid", i), 32'(res_valid_o), 32'h1);
      chk(vreq(i), $sformatf("vec%0d hit", i), 32'(hit_o), 32'(VECS[i].hit));
      chk(vreq(i), $sformatf("vec%0d cinh", i), 32'(cinh_o), 32'(VECS[i].ci));
      chk("R8", $sformatf("vec%0d paddr", i), paddr_o, VECS[i].addr);
    end

    // R2 writable fields and reserved bits
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R2", "all-ones readback", d, 32'hFFFF_8777);
    wr(0, 32'h0000_7888);
    rd(0, d); chk("R2", "reserved-only readback", d, 32'h0);
    rd(1, d); chk("R2", "other reg untouched", d, 32'hFFFF_8777);

    // R3 write and access at the same edge: old value used, then new
    wr(1, 32'h0);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 32'h40008107;
    acc_valid_i = 1'b1; acc_addr_i = 32'h40000000; acc_fc_i = 3'd1; acc_rd_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
    chk("R3", "same-edge write not seen", 32'(hit_o), 32'h0);
    chk("R3", "res_valid after strobe", 32'(res_valid_o), 32'h1);
    @(negedge clk);
    acc_valid_i = 1'b0;
    chk("R3", "next access sees write", 32'(hit_o), 32'h1);
    @(negedge clk);
    chk("R3", "res_valid drops", 32'(res_valid_o), 32'h0);
    chk("R10", "hit low without result", 32'(hit_o), 32'h0);
    chk("R10", "cinh low without result", 32'(cinh_o), 32'h0);

    // R1 reset mid-run clears registers
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd(0, d); chk("R1", "reg0 after reset", d, 32'h0);
    access(32'h40000000, 3'd1, 1'b1);
    chk("R1", "miss after reset", 32'(hit_o), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule